// File: doc/BRIEF.md
# Dual Event Counter with Delayed Overflow Interrupt

This block keeps two free-running event counters for performance measurement. Each counter picks its event source on its own. The source is either one of seven internal event strobes or a dedicated external pin for that counter. The counts cannot be read. Software learns about activity only through an overflow interrupt, which each counter raises a fixed six cycles after the event that wraps it.

Each counter has an overflow range that can be selected. Counter 0 wraps every 2^16 or 2^12 events, and counter 1 every 2^12 or 2^8 events. Reset clears the counts and nothing else ever does. Changing the source or the range therefore leaves the count where it is, so the first interrupt after such a change can come at any point within the new range. Each interrupt output is a sticky request, which is cleared by writing a one to its acknowledge bit.

Top module: `evt_ctr_pair`

## Requirements
- R1: While reset is asserted, and after it is released, both irq bits read 0 until an overflow occurs.
- R2: A source select value s in 0..6 counts evt_strb[s]. The value 7 counts rising edges of that counter's ext_pin bit. Strobes on lines that are not selected leave the count unchanged.
- R3: When rng_short[c] is 0, counter 0 overflows every 65536 events and counter 1 every 4096. When rng_short[c] is 1, counter 0 overflows every 4096 events and counter 1 every 256.
- R4: If the overflowing event is sampled at clock edge k, irq[c] rises just after edge k+6 and not earlier.
- R5: Changing a counter's source select or range select does not clear its count.
- R6: ext_pin[c] passes through a two-flop synchronizer and a rising-edge detector, so each low-to-high transition counts exactly once, however long the pin stays high.
- R7: irq[c] stays set until an edge samples irq_ack[c] at 1, and it reads 0 after that edge. An acknowledge bit at 0, or the acknowledge bit of the other counter, has no effect.
- R8: If a delayed overflow arrives on the same edge as an acknowledge, irq[c] stays set.
- R9: The two counters are independent. Events and overflows on one never change the other's irq.
- R10: Clearing irq[c] while an overflow is still travelling through the delay does not cancel that overflow. irq[c] sets again six edges after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_strb | input | 7 | Internal event strobes, one event per cycle high |
| ext_pin | input | 2 | External event pins, bit c feeds counter c |
| sel0 | input | 3 | Source select of counter 0 (0..6 strobe, 7 pin) |
| sel1 | input | 3 | Source select of counter 1 (0..6 strobe, 7 pin) |
| rng_short | input | 2 | Range select per counter, 1 selects the short range |
| irq_ack | input | 2 | Write-one-to-clear acknowledge per interrupt |
| irq | output | 2 | Sticky overflow interrupt requests |

## Verification
A count that is wrong because of an extra event, a missed event or a clear on a select change cannot be seen until the next overflow. It then shows as an interrupt on the wrong cycle, which can be a full range of events (up to 65536 cycles) after the fault. For this reason every overflow in the bench is predicted to the exact edge from a count model, and the interrupt is checked in each of the six cycles after the last event. A fault in the delay line or in the sticky bit shows within those six cycles, as an early, late, lost or wrongly cleared request.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int NUM_INT_EVT = 7;
  localparam int SEL_W       = $clog2(NUM_INT_EVT + 1);
  localparam int NUM_CTR     = 2;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sr_q <= '0;
    else           sr_q <= sr_d;
  end

  assign rst_n_out = sr_q[STAGES-1];
endmodule

// File: rtl/evt_pin_edge.sv
module evt_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R6: a detected edge lasts one cycle only
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 12,
  parameter int DELAY   = 6,
  parameter int NUM_EVT = 7,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               ext_rise,
  input  logic [SEL_W-1:0]   sel,
  input  logic               rng_short,
  input  logic               ack,
  output logic               irq
);
  logic [NUM_EVT:0] src;
  logic             hit;
  logic             lo_full;
  logic             hi_full;
  logic             ovf;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DELAY-1:0] pipe_q, pipe_d;
  logic             tail;
  logic             irq_q, irq_d;

  assign src = {ext_rise, evt};

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i <= NUM_EVT; i++) begin
      if (sel == SEL_W'(i)) hit = src[i];
    end
  end

  assign lo_full = &cnt_q[SHORT_W-1:0];
  assign hi_full = &cnt_q[CNT_W-1:SHORT_W];
  assign ovf     = hit & lo_full & (rng_short | hi_full);
  assign cnt_en  = hit;
  assign tail    = pipe_q[DELAY-1];

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    pipe_d = {pipe_q[DELAY-2:0], ovf};
    irq_d  = tail | (irq_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pipe_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      pipe_q <= pipe_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  // R3: an overflow leaves the low range bits at zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q[SHORT_W-1:0] == '0));
  // R5: without a selected event the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cnt_q));
  // R7: request is sticky without acknowledge
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);
  // R7: acknowledge clears when nothing arrives
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && ack && !tail) |=> !irq_q);
  // R8: delayed overflow always sets the request
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail |=> irq_q);
  // R4: the request only rises from the end of the delay line
  p_rise_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(tail));
endmodule

// File: rtl/evt_ctr_pair.sv
module evt_ctr_pair
  import evt_ctr_pkg::*;
#(
  parameter int CNT0_W       = 16,
  parameter int CNT0_SHORT_W = 12,
  parameter int CNT1_W       = 12,
  parameter int CNT1_SHORT_W = 8,
  parameter int IRQ_DELAY    = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_INT_EVT-1:0] evt_strb,
  input  logic [NUM_CTR-1:0]     ext_pin,
  input  logic [SEL_W-1:0]       sel0,
  input  logic [SEL_W-1:0]       sel1,
  input  logic [NUM_CTR-1:0]     rng_short,
  input  logic [NUM_CTR-1:0]     irq_ack,
  output logic [NUM_CTR-1:0]     irq
);
  logic                rst_n_s;
  logic [NUM_CTR-1:0]  ext_rise;

  evt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam int CW = (g == 0) ? CNT0_W : CNT1_W;
    localparam int SW = (g == 0) ? CNT0_SHORT_W : CNT1_SHORT_W;
    logic [SEL_W-1:0] sel_g;
    assign sel_g = (g == 0) ? sel0 : sel1;

    evt_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n_s),
      .pin   (ext_pin[g]),
      .rise  (ext_rise[g])
    );

    evt_counter #(
      .CNT_W   (CW),
      .SHORT_W (SW),
      .DELAY   (IRQ_DELAY),
      .NUM_EVT (NUM_INT_EVT),
      .SEL_W   (SEL_W)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .evt       (evt_strb),
      .ext_rise  (ext_rise[g]),
      .sel       (sel_g),
      .rng_short (rng_short[g]),
      .ack       (irq_ack[g]),
      .irq       (irq[g])
    );
  end
endmodule

// File: tb/tb_evt_ctr_pair.sv
`timescale 1ns/1ps
module tb_evt_ctr_pair;
  logic       clk;
  logic       rst_n;
  logic [6:0] evt_strb;
  logic [1:0] ext_pin;
  logic [2:0] sel0, sel1;
  logic [1:0] rng_short;
  logic [1:0] irq_ack;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  int m[2];
  bit done = 0;

  evt_ctr_pair dut (
    .clk(clk), .rst_n(rst_n), .evt_strb(evt_strb), .ext_pin(ext_pin),
    .sel0(sel0), .sel1(sel1), .rng_short(rng_short), .irq_ack(irq_ack),
    .irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sel_of(input int c);
    return (c == 0) ? int'(sel0) : int'(sel1);
  endfunction

  function automatic int range_of(input int c);
    if (c == 0) return rng_short[0] ? 4096 : 65536;
    return rng_short[1] ? 256 : 4096;
  endfunction

  task automatic drive_line(input int line, input int n);
    for (int i = 0; i < n; i++) begin
      evt_strb = 7'(1 << line);
      for (int c = 0; c < 2; c++) if (sel_of(c) == line) m[c]++;
      @(negedge clk);
    end
    evt_strb = '0;
  endtask

  task automatic do_ack(input logic [1:0] v);
    irq_ack = v;
    @(negedge clk);
    irq_ack = '0;
  endtask

  // Runs counter c to its next overflow on an internal line; ack_off>0 pulses ack
  task automatic count_to_ovf(input int c, input int line, input int ack_off, input string tag);
    int prior, rem, exp;
    prior = int'(irq[c]);
    rem = range_of(c) - (m[c] % range_of(c));
    drive_line(line, rem - 1);
    repeat (8) @(negedge clk);
    check({tag, " before last event"}, int'(irq[c]), prior);
    drive_line(line, 1);
    for (int i = 1; i <= 6; i++) begin
      if (i == ack_off) irq_ack[c] = 1'b1;
      @(negedge clk);
      irq_ack = '0;
      if (i >= 6) exp = 1;
      else if (ack_off > 0 && i >= ack_off) exp = 0;
      else exp = prior;
      check($sformatf("%s edge k+%0d", tag, i), int'(irq[c]), exp);
    end
  endtask

  task automatic ext_pulses(input int c, input int n, input int width);
    for (int p = 0; p < n; p++) begin
      ext_pin[c] = 1'b1;
      if (sel_of(c) == 7) m[c]++;
      repeat (width) @(negedge clk);
      ext_pin[c] = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 0; evt_strb = '0; ext_pin = '0; sel0 = 3'd6; sel1 = 3'd5;
    rng_short = '0; irq_ack = '0; m[0] = 0; m[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 irq during reset", int'(irq), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", int'(irq), 0);
  endtask

  task automatic t_short_c1;
    sel1 = 3'd2; rng_short[1] = 1'b1;
    count_to_ovf(1, 2, 0, "R3 R4 c1 short range");
    check("R9 irq0 untouched", int'(irq[0]), 0);
  endtask

  task automatic t_ack;
    do_ack(2'b01);
    check("R7 other ack ignored", int'(irq[1]), 1);
    do_ack(2'b00);
    check("R7 zero ack ignored", int'(irq[1]), 1);
    do_ack(2'b10);
    check("R7 ack clears", int'(irq[1]), 0);
  endtask

  task automatic t_sel_change;
    drive_line(2, 100);
    sel1 = 3'd4;
    drive_line(3, 50);
    count_to_ovf(1, 4, 0, "R5 R2 no clear on select change");
    do_ack(2'b10);
  endtask

  task automatic t_ext;
    int rem;
    sel1 = 3'd7;
    rem = 256 - (m[1] % 256);
    ext_pulses(1, 1, 20);
    ext_pulses(1, rem - 2, 2);
    repeat (12) @(negedge clk);
    check("R6 pin pulses before overflow", int'(irq[1]), 0);
    ext_pulses(1, 1, 3);
    repeat (12) @(negedge clk);
    check("R6 pin overflow", int'(irq[1]), 1);
  endtask

  task automatic t_set_wins;
    sel1 = 3'd2;
    count_to_ovf(1, 2, 6, "R8 set wins over ack");
  endtask

  task automatic t_in_flight;
    count_to_ovf(1, 2, 3, "R10 in-flight overflow");
    do_ack(2'b10);
    check("R10 ack after", int'(irq[1]), 0);
  endtask

  task automatic t_c0_short;
    sel0 = 3'd0; rng_short[0] = 1'b1;
    count_to_ovf(0, 0, 0, "R3 c0 short range");
    check("R9 irq1 untouched", int'(irq[1]), 0);
    do_ack(2'b01);
    check("R7 c0 ack", int'(irq[0]), 0);
  endtask

  task automatic t_c1_long;
    rng_short[1] = 1'b0; sel1 = 3'd1;
    count_to_ovf(1, 1, 0, "R3 R5 c1 long range");
    do_ack(2'b10);
  endtask

  task automatic t_c0_long;
    rng_short[0] = 1'b0;
    count_to_ovf(0, 0, 0, "R3 R5 c0 long range");
    check("R9 irq1 after c0 long", int'(irq[1]), 0);
    do_ack(2'b01);
  endtask

  initial begin
    t_reset();
    t_short_c1();
    t_ack();
    t_sel_change();
    t_ext();
    t_set_wins();
    t_in_flight();
    t_c0_short();
    t_c1_long();
    t_c0_long();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule